// File: doc/BRIEF.md
# Bus Slave Read Responder

This block is a read-only slave on a synchronous master bus. It sees a transfer start when the active-low start strobe is low at a rising clock edge. On that edge it captures the direction, size, address and a per-transfer wait-state count. On the next edge it looks at the active-low kill strobe. A killed transfer or a write gets no response of any kind. An unkilled read gets data from a small constant register array.

The response is a single cycle. In that cycle the block drives the 32-bit read bus, raises input-enable and pulls the acknowledge low, all at the same time. It drops all three at the next edge. Byte and halfword reads return the selected lane copied across the full bus. The master can start its next transfer on the same edge that samples the acknowledge.

Top module: `bus_read_slave`

## Requirements
- R1: After a synchronous reset, ack_n is high, ie is low and rdata is zero.
- R2: A read (rd_wr=1) sampled with start_n low has kill_n sampled at the next edge. If kill_n is high there and the wait count is 0, ack_n is low and ie is high during the cycle after that edge, for exactly one cycle.
- R3: If kill_n is low at the edge that follows the start edge, ack_n, ie and rdata show no response for that transfer.
- R4: A transfer started with rd_wr=0 (write) gets no response at all.
- R5: The wait count W (0 to 7) is sampled with the start and delays the response by exactly W cycles. During those cycles ack_n stays high and rdata stays zero.
- R6: The array holds 2**(ADDR_W-2) words and is indexed by addr[ADDR_W-1:2]. Word i is {i, i^8'hA5, 3*i+1, ~i}, with each field 8 bits wide, i truncated to 8 bits and the first field most significant. Size code 2'b00 (and 2'b11) returns the whole word.
- R7: Size code 2'b01 is a byte read. addr[1:0] picks the byte, with lane 0 at bits 31:24 and lane 3 at bits 7:0. The byte is repeated in all four lanes.
- R8: Size code 2'b10 is a halfword read. addr[1]=0 picks bits 31:16 and addr[1]=1 picks bits 15:0. The halfword is repeated in both halves.
- R9: rdata is zero in every cycle where ie is low, and ie is always the inverse of ack_n.
- R10: A start sampled on the edge that ends an acknowledge is accepted as a new transfer. The response returns to idle in the cycle after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start_n | input | 1 | Active-low transfer start strobe |
| kill_n | input | 1 | Active-low kill strobe, sampled one edge after start |
| rd_wr | input | 1 | 1 = read, 0 = write |
| size | input | 2 | 00 long, 01 byte, 10 halfword, 11 long |
| addr | input | ADDR_W | Byte address |
| wait_cfg | input | WAIT_W | Wait states before the response |
| rdata | output | 32 | Read data, zero unless ie is high |
| ie | output | 1 | Input-enable, high in the response cycle |
| ack_n | output | 1 | Active-low transfer acknowledge |

## Verification
The bench uses the default ADDR_W of 6 and WAIT_W of 3. That gives a 16-word array, so random addresses hit every word, every byte lane and both halfword halves many times. It also lets the bench exercise the full 0 to 7 wait range, with directed runs at both ends. Kills, writes and back-to-back starts on the acknowledge edge are mixed into the random traffic. Together they cover every path through the control state machine.

// File: rtl/bsr_pkg.sv
// Shared types and the constant array content of the read responder.
// Assumes a 32-bit data bus built from four byte lanes.
package bsr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_WAIT = 2'd2,
        ST_RESP = 2'd3
    } bsr_state_t;

    typedef enum logic [1:0] {
        SZ_LONG = 2'b00,
        SZ_BYTE = 2'b01,
        SZ_HALF = 2'b10,
        SZ_LINE = 2'b11
    } bsr_size_t;

    // Content of array word i: four byte fields derived from i.
    function automatic logic [31:0] init_word(input int idx);
        logic [7:0] b;
        b = idx[7:0];
        return {b, b ^ 8'hA5, (b * 8'd3) + 8'd1, ~b};
    endfunction

endpackage

// File: rtl/bsr_ctrl.sv
// Control for the read responder. It detects a start, checks the kill
// strobe one edge later, counts wait states and sends a one-cycle response.
// Assumes the master holds start_n high while it waits for an acknowledge.
module bsr_ctrl #(
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_n,
    input  logic              kill_n,
    input  logic              rd_wr,
    input  logic [WAIT_W-1:0] wait_cfg,
    output logic              cap_en,
    output logic              load,
    output logic              ie,
    output logic              ack_n
);
    import bsr_pkg::*;

    bsr_state_t        st_q, st_d;
    logic [WAIT_W-1:0] cnt_q, cnt_d;
    logic              rd_q;
    logic              ie_q, ack_n_q;

    // A start is taken only when idle or in the acknowledge cycle.
    assign cap_en = !start_n && (st_q == ST_IDLE || st_q == ST_RESP);

    // Next state and wait counter.
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        case (st_q)
            ST_IDLE, ST_RESP: begin
                if (cap_en) begin
                    st_d  = ST_ADDR;
                    cnt_d = wait_cfg;
                end else begin
                    st_d = ST_IDLE;
                end
            end
            ST_ADDR: begin
                if (!kill_n || !rd_q) begin
                    st_d = ST_IDLE;
                end else if (cnt_q == '0) begin
                    st_d = ST_RESP;
                end else begin
                    st_d  = ST_WAIT;
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_WAIT: begin
                if (cnt_q == '0) begin
                    st_d = ST_RESP;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    assign load = (st_d == ST_RESP) && (st_q != ST_RESP);

    // State, counter and captured direction registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            rd_q  <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            if (cap_en) rd_q <= rd_wr;
        end
    end

    // Response strobes, raised together for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q    <= 1'b0;
            ack_n_q <= 1'b1;
        end else begin
            ie_q    <= load;
            ack_n_q <= !load;
        end
    end

    assign ie    = ie_q;
    assign ack_n = ack_n_q;

    // R2
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n_q |=> ack_n_q);

    // R3
    kill_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ADDR && !kill_n) |=> ack_n_q);

    // R4
    write_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ADDR && !rd_q) |=> (ack_n_q && !ie_q));

    // R5
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT && cnt_q != '0) |=> ack_n_q);

endmodule

// File: rtl/bsr_lane.sv
// Formats an array word for the requested transfer size. A byte or
// halfword is copied across every lane. Purely combinational.
module bsr_lane (
    input  logic [1:0]  size,
    input  logic [1:0]  lane,
    input  logic [31:0] word,
    output logic [31:0] data
);
    import bsr_pkg::*;

    logic [7:0]  byte_sel;
    logic [15:0] half_sel;

    // Select the addressed byte; lane 0 is the most significant.
    always_comb begin
        case (lane)
            2'd0:    byte_sel = word[31:24];
            2'd1:    byte_sel = word[23:16];
            2'd2:    byte_sel = word[15:8];
            default: byte_sel = word[7:0];
        endcase
    end

    // Select the addressed halfword.
    assign half_sel = lane[1] ? word[15:0] : word[31:16];

    // Copy the selection across the bus according to size.
    always_comb begin
        case (bsr_size_t'(size))
            SZ_BYTE: data = {4{byte_sel}};
            SZ_HALF: data = {2{half_sel}};
            default: data = word;
        endcase
    end

endmodule

// File: rtl/bsr_regfile.sv
// Constant word array plus the address and size capture registers.
// Assumes cap_en pulses on the edge that accepts a start.
module bsr_regfile #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic [31:0]       fmt_data
);
    localparam int IDX_W = ADDR_W - 2;
    localparam int DEPTH = 1 << IDX_W;

    logic [31:0]      mem [DEPTH];
    logic [IDX_W-1:0] idx_q;
    logic [1:0]       lane_q;
    logic [1:0]       size_q;

    // One constant entry per word.
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        assign mem[g] = bsr_pkg::init_word(g);
    end

    // Capture the address and size that come with the start strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            lane_q <= '0;
            size_q <= '0;
        end else if (cap_en) begin
            idx_q  <= addr[ADDR_W-1:2];
            lane_q <= addr[1:0];
            size_q <= size;
        end
    end

    bsr_lane u_lane (
        .size (size_q),
        .lane (lane_q),
        .word (mem[idx_q]),
        .data (fmt_data)
    );

endmodule

// File: rtl/bus_read_slave.sv
// Top of the read responder: control, array and the read data register.
// Assumes one master and no other slave on the read bus.
module bus_read_slave #(
    parameter int ADDR_W = 6,
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_n,
    input  logic              kill_n,
    input  logic              rd_wr,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WAIT_W-1:0] wait_cfg,
    output logic [31:0]       rdata,
    output logic              ie,
    output logic              ack_n
);
    logic        cap_en;
    logic        load;
    logic [31:0] fmt_data;
    logic [31:0] rdata_q;

    bsr_ctrl #(.WAIT_W(WAIT_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_n  (start_n),
        .kill_n   (kill_n),
        .rd_wr    (rd_wr),
        .wait_cfg (wait_cfg),
        .cap_en   (cap_en),
        .load     (load),
        .ie       (ie),
        .ack_n    (ack_n)
    );

    bsr_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .addr     (addr),
        .size     (size),
        .fmt_data (fmt_data)
    );

    // Read data register, zero outside the response cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= load ? fmt_data : '0;
    end

    assign rdata = rdata_q;

    // R9
    bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ie |-> (rdata == '0));

    // R9
    ie_ack_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ie == !ack_n);

endmodule

// File: tb/bus_read_slave_tb.sv
module bus_read_slave_tb;
    localparam int ADDR_W = 6;
    localparam int WAIT_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_n = 1'b1;
    logic              kill_n = 1'b1;
    logic              rd_wr = 1'b1;
    logic [1:0]        size = 2'b00;
    logic [ADDR_W-1:0] addr = '0;
    logic [WAIT_W-1:0] wait_cfg = '0;
    logic [31:0]       rdata;
    logic              ie;
    logic              ack_n;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    bus_read_slave #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) u_dut (
        .clk (clk), .rst_n (rst_n), .start_n (start_n), .kill_n (kill_n),
        .rd_wr (rd_wr), .size (size), .addr (addr), .wait_cfg (wait_cfg),
        .rdata (rdata), .ie (ie), .ack_n (ack_n)
    );

    function automatic logic [31:0] word_of(input int i);
        logic [7:0] b;
        b = i[7:0];
        return {b, b ^ 8'hA5, 8'(b * 3 + 1), ~b};
    endfunction

    function automatic logic [31:0] expect_data(input logic [ADDR_W-1:0] a,
                                                input logic [1:0] sz);
        logic [31:0] w;
        logic [7:0]  b;
        logic [15:0] h;
        w = word_of(int'(a[ADDR_W-1:2]));
        b = 8'(w >> (8 * (3 - int'(a[1:0]))));
        h = a[1] ? w[15:0] : w[31:16];
        if (sz == 2'b01) return {4{b}};
        if (sz == 2'b10) return {2{h}};
        return w;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic check_quiet(input string req);
        check(ack_n === 1'b1 && ie === 1'b0 && rdata === 32'h0, req,
              {ack_n, ie, rdata[29:0]}, 32'h8000_0000);
    endtask

    // Called right after a negedge; returns right after a negedge.
    task automatic txn(input logic [ADDR_W-1:0] a, input logic [1:0] sz,
                       input logic [WAIT_W-1:0] w, input bit kill, input bit rw);
        logic [31:0] exp;
        start_n  = 1'b0;
        addr     = a;
        size     = sz;
        wait_cfg = w;
        rd_wr    = rw;
        @(negedge clk);
        check_quiet("R10 idle after start edge");
        start_n = 1'b1;
        kill_n  = !kill;
        addr    = '1;
        size    = 2'b11;
        rd_wr   = !rw;
        @(negedge clk);
        kill_n = 1'b1;
        if (!kill && rw) begin
            for (int k = 0; k < int'(w); k++) begin
                check_quiet("R5 wait cycle");
                @(negedge clk);
            end
            exp = expect_data(a, sz);
            check(ack_n === 1'b0 && ie === 1'b1, "R2 ack and ie",
                  {30'h0, ack_n, ie}, 32'h1);
            if (sz == 2'b01)      check(rdata === exp, "R7 byte data", rdata, exp);
            else if (sz == 2'b10) check(rdata === exp, "R8 half data", rdata, exp);
            else                  check(rdata === exp, "R6 long data", rdata, exp);
        end else begin
            for (int k = 0; k < 9; k++) begin
                check_quiet(kill ? "R3 killed" : "R4 write");
                @(negedge clk);
            end
        end
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        check_quiet("R9 idle");
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check_quiet("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_quiet("R1 after release");

        // Directed corner cases.
        txn(6'h00, 2'b00, 3'd0, 1'b0, 1'b1);
        idle_cycle();
        txn(6'h3C, 2'b11, 3'd7, 1'b0, 1'b1);
        idle_cycle();
        for (int l = 0; l < 4; l++) begin
            txn(6'(20 + l), 2'b01, 3'(l), 1'b0, 1'b1);
        end
        idle_cycle();
        txn(6'h0A, 2'b10, 3'd1, 1'b0, 1'b1);
        txn(6'h08, 2'b10, 3'd0, 1'b0, 1'b1);
        idle_cycle();
        txn(6'h10, 2'b00, 3'd0, 1'b1, 1'b1);
        txn(6'h14, 2'b00, 3'd7, 1'b0, 1'b0);
        txn(6'h18, 2'b00, 3'd3, 1'b1, 1'b0);
        idle_cycle();

        // Constrained random traffic.
        for (int n = 0; n < 300; n++) begin
            logic [ADDR_W-1:0] a;
            logic [1:0]        sz;
            logic [WAIT_W-1:0] w;
            bit                kl;
            bit                rw;
            a  = ADDR_W'($urandom);
            sz = 2'($urandom);
            w  = WAIT_W'($urandom);
            kl = ($urandom % 6) == 0;
            rw = ($urandom % 6) != 0;
            txn(a, sz, w, kl, rw);
            repeat ($urandom % 3) idle_cycle();
        end
        idle_cycle();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule